// File: doc/BRIEF.md
# Digital Potentiometer Serial Command Engine

This block is the byte-level command layer of a 2-wire bus slave that sets one 10-bit digital potentiometer. A bit-level front end handles the bus wires. It passes start and stop events, received bytes, and the end of each slave-transmitted byte together with the master's acknowledge bit. The engine checks the slave address byte against a fixed device type and two strap pins. It decodes the opcode and register pointer byte, and it decides which bytes earn an acknowledge. It also splits and joins 10-bit values across two data bytes.

Reads fetch their value from an external register bank through a select and value pair. Writes and transfers go to that bank as a single request pulse. The pulse is issued only once a stop closes a complete, fully acknowledged command. While the bank reports a nonvolatile store in progress, the engine withholds the acknowledge from its own address, so the master can poll until the store is done.

Top module: `dpot_cmd_engine`

## Requirements
- R1: The address byte is accepted only when bits [7:4] = 0101, bit 3 = 0 and bits [2:1] equal `strap_addr`. Bit 0 is the direction (1 = read). Any other byte gets no acknowledge, and every later byte is ignored until the next start.
- R2: While `nv_busy` is 1, a matching address byte gets no acknowledge and is treated as a mismatch.
- R3: The instruction byte carries the opcode in bits [7:5] and the register pointer in bits [3:2]. Bit 4 and bits [1:0] must be 0, or the byte gets no acknowledge.
- R4: The valid {direction, opcode} pairs are: read WCR = 1,100; read DR = 1,101; write WCR = 0,101; write DR = 0,110; DR to WCR transfer = 0,100; WCR to DR transfer = 0,111. A valid pair is acknowledged. Any other pair is not, and the engine goes idle.
- R5: From the cycle after an accepted instruction byte, `rd_from_dr` is 1 exactly for read DR, and `rd_ptr` holds the pointer. One cycle later, `rd_value` is captured.
- R6: On a read, the first byte is six zero bits followed by value bits 9:8. It is valid (`tx_valid` = 1) in the cycle after capture. After a master acknowledge, the second byte is value bits 7:0. After that byte completes, `tx_valid` drops.
- R7: If the master does not acknowledge the first read byte, `tx_valid` falls in the next cycle and stays low until a new start.
- R8: On a write, both data bytes are acknowledged. The value is {first byte bits 1:0, second byte}, and the upper six bits of the first byte are ignored.
- R9: One cycle after a stop that ends a complete command, `req_valid` pulses for one cycle. `req_op` is 0 for write WCR, 1 for write DR, 2 for DR to WCR and 3 for WCR to DR. `req_ptr` is the pointer, and `req_data` is the written value (0 for transfers).
- R10: A start or stop arriving before a command is complete cancels it, and no request follows.
- R11: A byte received after a complete write or transfer gets no acknowledge, and the following stop issues no request.
- R12: After reset, every output is 0.
- R13: `ack_en` holds its decision from the cycle after a byte until the next start, stop, byte or transmit completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 2 | Address strap pins |
| nv_busy | input | 1 | Nonvolatile store in progress |
| ev_start | input | 1 | Start condition seen (pulse) |
| ev_stop | input | 1 | Stop condition seen (pulse) |
| rx_valid | input | 1 | Byte received from master (pulse) |
| rx_byte | input | 8 | Received byte, MSB first on the bus |
| ack_en | output | 1 | Drive acknowledge for the last received byte |
| tx_valid | output | 1 | Slave has a byte to shift out |
| tx_byte | output | 8 | Byte to shift out |
| tx_done | input | 1 | Transmitted byte and its acknowledge slot finished (pulse) |
| mst_ack | input | 1 | Master acknowledge bit sampled with `tx_done` (1 = ACK) |
| rd_from_dr | output | 1 | Read source: 1 = data register, 0 = wiper register |
| rd_ptr | output | 2 | Data register pointer for reads |
| rd_value | input | 10 | Value returned by the register bank |
| req_valid | output | 1 | Write or transfer request (pulse) |
| req_op | output | 2 | Request kind |
| req_ptr | output | 2 | Data register pointer of the request |
| req_data | output | 10 | Value to write |

## Verification
Every output is registered. `ack_en` and the read select are therefore due in the cycle that follows the edge that samples a byte. The first read byte arrives one cycle after that, and the request pulse arrives in the cycle after the edge that samples the stop. The bench applies each event for one cycle from a falling edge. It then updates its expected outputs just after the next rising edge and compares every output at each falling edge, so each result is checked in the exact cycle it is due and in every cycle it must hold. The expected values come from a behavioural model of the command table and of a four-plus-one-entry register bank, which the bench also serves to the design.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam int BYTE_W   = 8;
    localparam int SEL_W    = 2;
    localparam int VALUE_W  = 10;
    localparam logic [3:0] DEV_TYPE = 4'b0101;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_INSTR, S_LOAD, S_RD_HI, S_RD_LO,
        S_WR_HI, S_WR_LO, S_DONE, S_HOLD
    } eng_state_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_RD_WCR, OP_RD_DR, OP_WR_WCR, OP_WR_DR, OP_DR2WCR, OP_WCR2DR
    } cmd_t;

    typedef struct packed {
        cmd_t             cmd;
        logic [SEL_W-1:0] ptr;
    } instr_t;

    function automatic logic is_read(cmd_t c);
        return (c == OP_RD_WCR) || (c == OP_RD_DR);
    endfunction

    function automatic logic is_write(cmd_t c);
        return (c == OP_WR_WCR) || (c == OP_WR_DR);
    endfunction

    function automatic logic [1:0] to_req(cmd_t c);
        case (c)
            OP_WR_WCR: return 2'd0;
            OP_WR_DR:  return 2'd1;
            OP_DR2WCR: return 2'd2;
            default:   return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/dpot_addr_check.sv
module dpot_addr_check
    import dpot_pkg::*;
#(
    parameter int STRAP_W = 2
) (
    input  logic [BYTE_W-1:0]  addr_byte,
    input  logic [STRAP_W-1:0] strap,
    input  logic               busy,
    output logic               match,
    output logic               dir_read
);
    always_comb begin
        match    = (addr_byte[7:4] == DEV_TYPE) && !addr_byte[3]
                   && (addr_byte[STRAP_W:1] == strap) && !busy;
        dir_read = addr_byte[0];
    end
endmodule

// File: rtl/dpot_instr_decode.sv
module dpot_instr_decode
    import dpot_pkg::*;
(
    input  logic [BYTE_W-1:0] ins_byte,
    input  logic              dir_read,
    output instr_t            dec
);
    always_comb begin
        dec.ptr = ins_byte[3:2];
        dec.cmd = OP_NONE;
        if (!ins_byte[4] && (ins_byte[1:0] == 2'b00)) begin
            case ({dir_read, ins_byte[7:5]})
                4'b1100: dec.cmd = OP_RD_WCR;
                4'b1101: dec.cmd = OP_RD_DR;
                4'b0101: dec.cmd = OP_WR_WCR;
                4'b0110: dec.cmd = OP_WR_DR;
                4'b0100: dec.cmd = OP_DR2WCR;
                4'b0111: dec.cmd = OP_WCR2DR;
                default: dec.cmd = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dpot_tx_slicer.sv
module dpot_tx_slicer
    import dpot_pkg::*;
#(
    parameter int VAL_W = VALUE_W
) (
    input  logic [VAL_W-1:0]  value,
    input  logic              low_half,
    output logic [BYTE_W-1:0] tx
);
    localparam int HI_W = VAL_W - BYTE_W;
    localparam int PAD  = BYTE_W - HI_W;

    always_comb begin
        if (low_half) tx = value[BYTE_W-1:0];
        else          tx = {{PAD{1'b0}}, value[VAL_W-1:BYTE_W]};
    end
endmodule

// File: rtl/dpot_cmd_engine.sv
module dpot_cmd_engine
    import dpot_pkg::*;
#(
    parameter int VAL_W   = VALUE_W,
    parameter int STRAP_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic               nv_busy,
    input  logic               ev_start,
    input  logic               ev_stop,
    input  logic               rx_valid,
    input  logic [BYTE_W-1:0]  rx_byte,
    output logic               ack_en,
    output logic               tx_valid,
    output logic [BYTE_W-1:0]  tx_byte,
    input  logic               tx_done,
    input  logic               mst_ack,
    output logic               rd_from_dr,
    output logic [SEL_W-1:0]   rd_ptr,
    input  logic [VAL_W-1:0]   rd_value,
    output logic               req_valid,
    output logic [1:0]         req_op,
    output logic [SEL_W-1:0]   req_ptr,
    output logic [VAL_W-1:0]   req_data
);
    localparam int HI_W = VAL_W - BYTE_W;

    eng_state_t       st;
    cmd_t             cmd_q;
    logic [SEL_W-1:0] ptr_q;
    logic [VAL_W-1:0] val_q;
    logic             dir_q;
    logic             tx_lo;
    logic             addr_ok;
    logic             addr_dir;
    instr_t           dec;

    dpot_addr_check #(.STRAP_W(STRAP_W)) u_addr (
        .addr_byte(rx_byte), .strap(strap_addr), .busy(nv_busy),
        .match(addr_ok), .dir_read(addr_dir)
    );

    dpot_instr_decode u_dec (
        .ins_byte(rx_byte), .dir_read(dir_q), .dec(dec)
    );

    dpot_tx_slicer #(.VAL_W(VAL_W)) u_slice (
        .value(val_q), .low_half(tx_lo), .tx(tx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            cmd_q      <= OP_NONE;
            ptr_q      <= '0;
            val_q      <= '0;
            dir_q      <= 1'b0;
            tx_lo      <= 1'b0;
            ack_en     <= 1'b0;
            tx_valid   <= 1'b0;
            rd_from_dr <= 1'b0;
            rd_ptr     <= '0;
            req_valid  <= 1'b0;
            req_op     <= '0;
            req_ptr    <= '0;
            req_data   <= '0;
        end else begin
            req_valid <= 1'b0;
            if (ev_start) begin
                st       <= S_ADDR;
                ack_en   <= 1'b0;
                tx_valid <= 1'b0;
            end else if (ev_stop) begin
                if (st == S_DONE) begin
                    req_valid <= 1'b1;
                    req_op    <= to_req(cmd_q);
                    req_ptr   <= ptr_q;
                    req_data  <= val_q;
                end
                st       <= S_IDLE;
                ack_en   <= 1'b0;
                tx_valid <= 1'b0;
            end else if (rx_valid) begin
                ack_en <= 1'b0;
                case (st)
                    S_ADDR: begin
                        if (addr_ok) begin
                            ack_en <= 1'b1;
                            dir_q  <= addr_dir;
                            st     <= S_INSTR;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                    S_INSTR: begin
                        if (dec.cmd != OP_NONE) begin
                            ack_en     <= 1'b1;
                            cmd_q      <= dec.cmd;
                            ptr_q      <= dec.ptr;
                            val_q      <= '0;
                            rd_from_dr <= (dec.cmd == OP_RD_DR);
                            rd_ptr     <= dec.ptr;
                            if (is_read(dec.cmd))       st <= S_LOAD;
                            else if (is_write(dec.cmd)) st <= S_WR_HI;
                            else                        st <= S_DONE;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                    S_WR_HI: begin
                        ack_en                  <= 1'b1;
                        val_q[VAL_W-1:BYTE_W]   <= rx_byte[HI_W-1:0];
                        st                      <= S_WR_LO;
                    end
                    S_WR_LO: begin
                        ack_en              <= 1'b1;
                        val_q[BYTE_W-1:0]   <= rx_byte;
                        st                  <= S_DONE;
                    end
                    S_DONE:  st <= S_HOLD;
                    S_HOLD:  st <= S_HOLD;
                    default: st <= S_IDLE;
                endcase
            end else if (tx_done) begin
                ack_en <= 1'b0;
                if (st == S_RD_HI) begin
                    if (mst_ack) begin
                        tx_lo <= 1'b1;
                        st    <= S_RD_LO;
                    end else begin
                        tx_valid <= 1'b0;
                        st       <= S_HOLD;
                    end
                end else if (st == S_RD_LO) begin
                    tx_valid <= 1'b0;
                    st       <= S_HOLD;
                end
            end else if (st == S_LOAD) begin
                val_q    <= rd_value;
                tx_lo    <= 1'b0;
                tx_valid <= 1'b1;
                st       <= S_RD_HI;
            end
        end
    end

    // R2: a busy store suppresses the address acknowledge
    a_r2_busy_no_ack: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !ev_start && !ev_stop && st == S_ADDR && nv_busy) |=> !ack_en);

    // R9: a request only ever follows a stop
    a_r9_req_after_stop: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $past(ev_stop));

    // R10: a start clears every pending output
    a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (!req_valid && !tx_valid && !ack_en));

    // R7: a master NACK on the first read byte releases the line
    a_r7_nack_release: assert property (@(posedge clk) disable iff (rst)
        (st == S_RD_HI && tx_done && !mst_ack && !ev_start && !ev_stop && !rx_valid)
        |=> !tx_valid);

    // R6: the first read byte carries only the top value bits
    a_r6_hi_pad: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && st == S_RD_HI) |-> (tx_byte[BYTE_W-1:HI_W] == '0));

    // R9: request pulse lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);
endmodule

// File: tb/dpot_cmd_engine_bench.sv
module dpot_cmd_engine_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] strap_addr = 2'b10;
    logic       nv_busy = 1'b0;
    logic       ev_start = 1'b0, ev_stop = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_done = 1'b0, mst_ack = 1'b0;
    logic       ack_en, tx_valid, rd_from_dr, req_valid;
    logic [7:0] tx_byte;
    logic [1:0] rd_ptr, req_op, req_ptr;
    logic [9:0] rd_value, req_data;

    logic [9:0] m_wcr = 10'h000;
    logic [9:0] m_dr [4];

    logic       e_ack = 0, e_txv = 0, e_rfd = 0, e_req = 0;
    logic [7:0] e_txb = 0;
    logic [1:0] e_rptr = 0, e_rop = 0, e_qptr = 0;
    logic [9:0] e_qdat = 0;

    int    checks = 0;
    int    errors = 0;
    string tag = "R12";
    bit    running = 1'b0;

    localparam logic [7:0] ADDR_WR = 8'h54;
    localparam logic [7:0] ADDR_RD = 8'h55;

    always #5 clk = ~clk;

    assign rd_value = rd_from_dr ? m_dr[rd_ptr] : m_wcr;

    dpot_cmd_engine u_dpot_cmd_engine (
        .clk(clk), .rst(rst), .strap_addr(strap_addr), .nv_busy(nv_busy),
        .ev_start(ev_start), .ev_stop(ev_stop), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .ack_en(ack_en), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_done(tx_done), .mst_ack(mst_ack),
        .rd_from_dr(rd_from_dr), .rd_ptr(rd_ptr), .rd_value(rd_value),
        .req_valid(req_valid), .req_op(req_op), .req_ptr(req_ptr),
        .req_data(req_data)
    );

    task automatic chk(input string field, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, field, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst) begin
            chk("ack_en", ack_en, e_ack);
            chk("tx_valid", tx_valid, e_txv);
            if (e_txv) chk("tx_byte", tx_byte, e_txb);
            chk("rd_from_dr", rd_from_dr, e_rfd);
            chk("rd_ptr", rd_ptr, e_rptr);
            chk("req_valid", req_valid, e_req);
            if (e_req) begin
                chk("req_op", req_op, e_rop);
                chk("req_ptr", req_ptr, e_qptr);
                chk("req_data", req_data, e_qdat);
            end
        end
    end

    // kind: 0 start, 1 stop, 2 byte, 3 transmit done, other idle
    task automatic ev(input int kind, input logic [7:0] b, input logic a);
        @(negedge clk);
        case (kind)
            0: ev_start = 1'b1;
            1: ev_stop = 1'b1;
            2: begin rx_valid = 1'b1; rx_byte = b; end
            3: begin tx_done = 1'b1; mst_ack = a; end
            default: ;
        endcase
        @(posedge clk);
        #1;
        ev_start = 1'b0; ev_stop = 1'b0; rx_valid = 1'b0;
        tx_done = 1'b0; mst_ack = 1'b0;
        e_req = 1'b0;
    endtask

    task automatic do_start();
        ev(0, 8'h00, 1'b0);
        e_ack = 0; e_txv = 0;
    endtask

    task automatic do_stop();
        ev(1, 8'h00, 1'b0);
        e_ack = 0; e_txv = 0;
    endtask

    task automatic stop_commit(input logic [1:0] op, input logic [1:0] ptr, input logic [9:0] d);
        ev(1, 8'h00, 1'b0);
        e_ack = 0; e_txv = 0;
        e_req = 1; e_rop = op; e_qptr = ptr; e_qdat = d;
        case (op)
            2'd0: m_wcr = d;
            2'd1: m_dr[ptr] = d;
            2'd2: m_wcr = m_dr[ptr];
            default: m_dr[ptr] = m_wcr;
        endcase
    endtask

    task automatic send(input logic [7:0] b, input logic ok);
        ev(2, b, 1'b0);
        e_ack = ok;
    endtask

    task automatic send_instr(input logic [7:0] b, input logic rd, input logic ok);
        send(b, ok);
        if (ok) begin
            e_rfd  = rd && (b[7:5] == 3'b101);
            e_rptr = b[3:2];
        end
    endtask

    task automatic write_cmd(input logic [7:0] ins, input logic [7:0] d1, input logic [7:0] d2,
                             input logic [1:0] op);
        do_start();
        send(ADDR_WR, 1);
        send_instr(ins, 0, 1);
        send(d1, 1);
        send(d2, 1);
        stop_commit(op, ins[3:2], {d1[1:0], d2});
    endtask

    task automatic xfer_cmd(input logic [7:0] ins, input logic [1:0] op);
        do_start();
        send(ADDR_WR, 1);
        send_instr(ins, 0, 1);
        stop_commit(op, ins[3:2], 10'h000);
    endtask

    task automatic read_cmd(input logic [7:0] ins, input logic hi_ack);
        logic [9:0] v;
        do_start();
        send(ADDR_RD, 1);
        send_instr(ins, 1, 1);
        v = (ins[7:5] == 3'b101) ? m_dr[ins[3:2]] : m_wcr;
        ev(4, 8'h00, 1'b0);
        e_txv = 1; e_txb = {6'b0, v[9:8]};
        ev(3, 8'h00, hi_ack);
        e_ack = 0;
        if (hi_ack) e_txb = v[7:0];
        else        e_txv = 0;
        if (hi_ack) begin
            ev(3, 8'h00, 1'b0);
            e_txv = 0;
        end else begin
            ev(3, 8'h00, 1'b1);
        end
        do_stop();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_dr[i] = 10'h000;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        running = 1'b1;
        tag = "R12";
        repeat (2) ev(4, 8'h00, 1'b0);

        tag = "R8";
        write_cmd(8'hA0, 8'hFE, 8'hA5, 2'd0);
        tag = "R9";
        write_cmd(8'hCC, 8'h01, 8'h3C, 2'd1);
        write_cmd(8'hC4, 8'h03, 8'hFF, 2'd1);

        tag = "R5";
        read_cmd(8'hAC, 1);
        tag = "R6";
        read_cmd(8'h80, 1);
        read_cmd(8'hA4, 1);
        tag = "R7";
        read_cmd(8'hAC, 0);

        tag = "R4";
        xfer_cmd(8'h8C, 2'd2);
        xfer_cmd(8'hE0, 2'd3);
        read_cmd(8'hA0, 1);
        read_cmd(8'h80, 1);

        tag = "R1";
        do_start(); send(8'h74, 0); send(8'hA0, 0); send(8'h00, 0); do_stop();
        do_start(); send(8'h52, 0); send(8'hA0, 0); do_stop();
        do_start(); send(8'h5C, 0); do_stop();

        tag = "R2";
        nv_busy = 1'b1;
        do_start(); send(ADDR_WR, 0); send(8'hA0, 0); do_stop();
        nv_busy = 1'b0;
        write_cmd(8'hA0, 8'h00, 8'h11, 2'd0);

        tag = "R4";
        do_start(); send(ADDR_RD, 1); send_instr(8'hC0, 1, 0); send(8'h00, 0); do_stop();
        do_start(); send(ADDR_WR, 1); send_instr(8'h00, 0, 0); do_stop();
        tag = "R3";
        do_start(); send(ADDR_WR, 1); send_instr(8'hA1, 0, 0); do_stop();
        do_start(); send(ADDR_WR, 1); send_instr(8'hB0, 0, 0); do_stop();

        tag = "R10";
        do_start(); send(ADDR_WR, 1); send_instr(8'hA0, 0, 1); send(8'h02, 1);
        do_start(); do_stop();
        do_start(); send(ADDR_WR, 1); send_instr(8'hCC, 0, 1); send(8'h02, 1); do_stop();
        write_cmd(8'hA0, 8'h03, 8'h0F, 2'd0);

        tag = "R11";
        do_start(); send(ADDR_WR, 1); send_instr(8'hA0, 0, 1); send(8'h01, 1); send(8'h55, 1);
        send(8'h66, 0); do_stop();
        do_start(); send(ADDR_WR, 1); send_instr(8'h88, 0, 1); send(8'h00, 0); do_stop();

        tag = "R13";
        do_start(); send(ADDR_WR, 1);
        repeat (3) ev(4, 8'h00, 1'b0);
        send_instr(8'hA0, 0, 1);
        repeat (3) ev(4, 8'h00, 1'b0);
        do_stop();
        read_cmd(8'h80, 1);

        repeat (2) ev(4, 8'h00, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule